// File: doc/BRIEF.md
# Segment Selector Load Protection Checker

This block decides whether a 16-bit selector may be loaded into the stack segment register or one of the data segment registers while the processor runs in protected mode. A request carries the target register, the selector, the current privilege level and the limit of the descriptor table. Any selector whose index field is nonzero needs its descriptor. For such a selector, the block first runs the checks that need no descriptor. If those pass, it asks for the descriptor's access-rights byte through a request/acknowledge handshake.

The block applies the remaining rules in a fixed priority order. The stack register and the data registers have different rules. It then reports one of three outcomes: an accepted load with the hidden valid bit set, an accepted null load with the valid bit cleared, or a fault class with its error value.

A null selector means something different for each register kind. Loading one into the stack register is a fault. Loading one into a data register is legal: it marks the register as holding nothing usable and needs no descriptor fetch.

Top module: `seg_load_guard`

## Requirements
- R1: After reset the outputs `busy`, `fetchReq`, `doneStb`, `loadAccept` and `hiddenValid` are 0, `excCode` is 0 (none) and `errCode` is 0.
- R2: A selector whose bits 15:2 are all zero (a null selector), loaded into the stack register (target code 0), ends with `excCode` = 1 (general protection) and `errCode` = 0. No fetch is requested.
- R3: A null selector loaded into a data register (any nonzero target code) is accepted with `excCode` = 0, `errCode` = 0 and `hiddenValid` = 0. No fetch is requested.
- R4: For a non-null selector the first check, for both register kinds, is the table limit. If the selector with its low three bits forced to 1 exceeds `tableLimit`, the result is `excCode` = 1 with `errCode` equal to the selector with bits 1:0 cleared, and no fetch is requested.
- R5: For the stack register, a selector that passes R4 but whose RPL (bits 1:0) differs from `reqCpl` gives `excCode` = 1 with the selector error value, and no fetch is requested.
- R6: For the stack register, the access byte is checked in this order. It must show a writable data segment (bit 4 = 1, bit 3 = 0, bit 1 = 1); otherwise the result is a general protection fault. Then its DPL (bits 6:5) must equal CPL; otherwise the result is a general protection fault. Then the present bit (bit 7) must be 1; otherwise the result is `excCode` = 2 (stack fault). Each of these faults carries the selector error value.
- R7: For a data register, the access byte must show a data segment (bit 4 = 1, bit 3 = 0) or a readable code segment (bit 4 = 1, bit 3 = 1, bit 1 = 1). Otherwise the result is `excCode` = 1 with the selector error value.
- R8: For a data register whose descriptor is data or non-conforming code (bit 3 = 0 or bit 2 = 0), both RPL and CPL must be at most DPL, or the result is `excCode` = 1 with the selector error value. Conforming readable code skips this check.
- R9: For a data register, a descriptor that passes R7 and R8 but has bit 7 = 0 gives `excCode` = 3 (not present) with the selector error value.
- R10: A load that passes every check is accepted: `loadAccept` and `doneStb` pulse together for exactly one cycle, `hiddenValid` = 1, `excCode` = 0 and `errCode` = 0.
- R11: `fetchReq` stays high until a cycle in which `fetchAck` is sampled high; the access byte is taken from that cycle. The result is reported on the following cycle. `reqValid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a check; taken only while not busy |
| reqTarget | input | TGT_W | 0 = stack register, nonzero = a data register |
| reqSel | input | 16 | Selector to load |
| reqCpl | input | 2 | Current privilege level |
| tableLimit | input | LIMIT_W | Byte limit of the descriptor table |
| busy | output | 1 | A check is in progress |
| fetchReq | output | 1 | Descriptor access byte requested |
| fetchAck | input | 1 | Access byte valid on `fetchAccess` |
| fetchAccess | input | 8 | Descriptor access-rights byte |
| doneStb | output | 1 | One-cycle result strobe |
| loadAccept | output | 1 | Load accepted (pulses with `doneStb`) |
| hiddenValid | output | 1 | Hidden valid bit of the last result |
| excCode | output | 2 | 0 none, 1 general protection, 2 stack fault, 3 not present |
| errCode | output | 16 | Fault error value, held until the next result |

## Verification
The bench builds the block with its default parameters: a 16-bit table limit and a 3-bit target code. With these values every selector index can be compared against limits right up to 0xFFFF, and the target codes 5 to 7, which are not named data registers, are still exercised as data targets. Random selectors are weighted toward the null range and toward an RPL equal to CPL, so that both the early faults and the descriptor-ordering paths are reached often. Acknowledge delays from zero to several cycles test how long the fetch request is held.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  localparam int SEL_W = 16;

  // access byte field positions
  localparam int ACC_PRESENT = 7;
  localparam int ACC_DPL_HI  = 6;
  localparam int ACC_DPL_LO  = 5;
  localparam int ACC_SEGDESC = 4;
  localparam int ACC_EXEC    = 3;
  localparam int ACC_CONF    = 2;
  localparam int ACC_RW      = 1;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_GP   = 2'd1,
    EXC_SS   = 2'd2,
    EXC_NP   = 2'd3
  } excCode_e;

  typedef struct packed {
    logic capture;
    logic finishPre;
    logic finishDesc;
  } guardStrobes_t;

  typedef struct packed {
    logic isNull;
    logic preFault;
  } guardStatus_t;

endpackage

// File: rtl/seg_guard_datapath.sv
module seg_guard_datapath
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16,
  parameter int TGT_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  guardStrobes_t      strobes,
  input  logic [TGT_W-1:0]   reqTarget,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic [1:0]         reqCpl,
  input  logic [LIMIT_W-1:0] tableLimit,
  input  logic [7:0]         fetchAccess,
  output guardStatus_t       status,
  output logic               loadAccept,
  output logic               hiddenValid,
  output logic [1:0]         excCode,
  output logic [SEL_W-1:0]   errCode
);

  localparam int CMP_W = (LIMIT_W > SEL_W) ? LIMIT_W : SEL_W;

  logic [TGT_W-1:0]   capTgt;
  logic [SEL_W-1:0]   capSel;
  logic [1:0]         capCpl;
  logic [LIMIT_W-1:0] capLim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTgt <= '0;
      capSel <= '0;
      capCpl <= '0;
      capLim <= '0;
    end else if (strobes.capture) begin
      capTgt <= reqTarget;
      capSel <= reqSel;
      capCpl <= reqCpl;
      capLim <= tableLimit;
    end
  end

  logic             toStack;
  logic [1:0]       selRpl;
  logic [SEL_W-1:0] selErr;
  logic [CMP_W-1:0] entryEnd;
  logic [CMP_W-1:0] limitExt;
  logic             limitFail;

  assign toStack  = (capTgt == '0);
  assign selRpl   = capSel[1:0];
  assign selErr   = {capSel[SEL_W-1:2], 2'b00};
  assign entryEnd = CMP_W'({capSel[SEL_W-1:3], 3'b111});
  assign limitExt = CMP_W'(capLim);
  assign limitFail = entryEnd > limitExt;

  assign status.isNull   = (capSel[SEL_W-1:2] == '0);
  assign status.preFault = limitFail || (toStack && (selRpl != capCpl));

  // descriptor verdict, priority ordered per register kind
  logic       accPresent, accSeg, accExec, accConf, accRw;
  logic [1:0] accDpl;
  excCode_e   descExc;

  assign accPresent = fetchAccess[ACC_PRESENT];
  assign accDpl     = fetchAccess[ACC_DPL_HI:ACC_DPL_LO];
  assign accSeg     = fetchAccess[ACC_SEGDESC];
  assign accExec    = fetchAccess[ACC_EXEC];
  assign accConf    = fetchAccess[ACC_CONF];
  assign accRw      = fetchAccess[ACC_RW];

  always_comb begin
    descExc = EXC_NONE;
    if (toStack) begin
      if (!(accSeg && !accExec && accRw))       descExc = EXC_GP;
      else if (accDpl != capCpl)                descExc = EXC_GP;
      else if (!accPresent)                     descExc = EXC_SS;
    end else begin
      if (!(accSeg && (!accExec || accRw)))     descExc = EXC_GP;
      else if ((!accExec || !accConf) &&
               ((selRpl > accDpl) || (capCpl > accDpl)))
                                                descExc = EXC_GP;
      else if (!accPresent)                     descExc = EXC_NP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadAccept  <= 1'b0;
      hiddenValid <= 1'b0;
      excCode     <= EXC_NONE;
      errCode     <= '0;
    end else if (strobes.finishPre) begin
      hiddenValid <= 1'b0;
      if (status.isNull) begin
        loadAccept <= !toStack;
        excCode    <= toStack ? EXC_GP : EXC_NONE;
        errCode    <= '0;
      end else begin
        loadAccept <= 1'b0;
        excCode    <= EXC_GP;
        errCode    <= selErr;
      end
    end else if (strobes.finishDesc) begin
      loadAccept  <= (descExc == EXC_NONE);
      hiddenValid <= (descExc == EXC_NONE);
      excCode     <= descExc;
      errCode     <= (descExc == EXC_NONE) ? '0 : selErr;
    end else begin
      loadAccept <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_guard_control.sv
module seg_guard_control
  import seg_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          fetchAck,
  input  guardStatus_t  status,
  output guardStrobes_t strobes,
  output logic          busy,
  output logic          fetchReq,
  output logic          doneStb
);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FETCH} guardState_e;
  guardState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobes.capture = 1'b1;
        stateNext       = ST_CHECK;
      end
      ST_CHECK: if (status.isNull || status.preFault) begin
        strobes.finishPre = 1'b1;
        stateNext         = ST_IDLE;
      end else begin
        stateNext = ST_FETCH;
      end
      ST_FETCH: if (fetchAck) begin
        strobes.finishDesc = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
    end else begin
      state   <= stateNext;
      doneStb <= strobes.finishPre || strobes.finishDesc;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign fetchReq = (state == ST_FETCH);

endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16,
  parameter int TGT_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [TGT_W-1:0]   reqTarget,
  input  logic [15:0]        reqSel,
  input  logic [1:0]         reqCpl,
  input  logic [LIMIT_W-1:0] tableLimit,
  output logic               busy,
  output logic               fetchReq,
  input  logic               fetchAck,
  input  logic [7:0]         fetchAccess,
  output logic               doneStb,
  output logic               loadAccept,
  output logic               hiddenValid,
  output logic [1:0]         excCode,
  output logic [15:0]        errCode
);

  guardStrobes_t strobes;
  guardStatus_t  status;

  seg_guard_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .fetchAck (fetchAck),
    .status   (status),
    .strobes  (strobes),
    .busy     (busy),
    .fetchReq (fetchReq),
    .doneStb  (doneStb)
  );

  seg_guard_datapath #(.LIMIT_W(LIMIT_W), .TGT_W(TGT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqTarget   (reqTarget),
    .reqSel      (reqSel),
    .reqCpl      (reqCpl),
    .tableLimit  (tableLimit),
    .fetchAccess (fetchAccess),
    .status      (status),
    .loadAccept  (loadAccept),
    .hiddenValid (hiddenValid),
    .excCode     (excCode),
    .errCode     (errCode)
  );

endmodule

// File: rtl/seg_load_guard_chk.sv
module seg_load_guard_chk #(
  parameter int TGT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [TGT_W-1:0] reqTarget,
  input logic [15:0]      reqSel,
  input logic             busy,
  input logic             fetchReq,
  input logic             fetchAck,
  input logic             doneStb,
  input logic             loadAccept,
  input logic             hiddenValid,
  input logic [1:0]       excCode,
  input logic [15:0]      errCode
);

  logic [15:0]      lastSel;
  logic [TGT_W-1:0] lastTgt;
  logic             lastNull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSel <= '0;
      lastTgt <= '0;
    end else if (reqValid && !busy) begin
      lastSel <= reqSel;
      lastTgt <= reqTarget;
    end
  end

  assign lastNull = (lastSel[15:2] == '0);

  // R2
  null_stack_gp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && lastTgt == '0 && lastNull) |-> (excCode == 2'd1 && errCode == 16'd0));

  // R3
  null_data_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStb && lastTgt != '0 && lastNull) |-> (loadAccept && !hiddenValid && excCode == 2'd0));

  // R3
  no_fetch_on_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> !lastNull);

  // R4
  err_low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (errCode[1:0] == 2'b00));

  // R10
  accept_is_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadAccept |-> (doneStb && excCode == 2'd0 && errCode == 16'd0));

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  // R11
  fetch_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> fetchReq);

  // R11
  fetch_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> busy);

endmodule

bind seg_load_guard seg_load_guard_chk #(.TGT_W(TGT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqTarget   (reqTarget),
  .reqSel      (reqSel),
  .busy        (busy),
  .fetchReq    (fetchReq),
  .fetchAck    (fetchAck),
  .doneStb     (doneStb),
  .loadAccept  (loadAccept),
  .hiddenValid (hiddenValid),
  .excCode     (excCode),
  .errCode     (errCode)
);

// File: tb/seg_load_guard_tb_top.sv
module seg_load_guard_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LIMIT_W = 16;
  localparam int TGT_W   = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic [TGT_W-1:0]   reqTarget = '0;
  logic [15:0]        reqSel = '0;
  logic [1:0]         reqCpl = '0;
  logic [LIMIT_W-1:0] tableLimit = '0;
  logic               busy, fetchReq, doneStb, loadAccept, hiddenValid;
  logic               fetchAck = 1'b0;
  logic [7:0]         fetchAccess = '0;
  logic [1:0]         excCode;
  logic [15:0]        errCode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seg_load_guard #(.LIMIT_W(LIMIT_W), .TGT_W(TGT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .reqSel(reqSel), .reqCpl(reqCpl), .tableLimit(tableLimit), .busy(busy),
    .fetchReq(fetchReq), .fetchAck(fetchAck), .fetchAccess(fetchAccess),
    .doneStb(doneStb), .loadAccept(loadAccept), .hiddenValid(hiddenValid),
    .excCode(excCode), .errCode(errCode)
  );

  typedef struct {
    int    exc;
    int    err;
    bit    accept;
    bit    hv;
    bit    fetch;
    string tag;
  } expect_t;

  function automatic expect_t model(int tgt, logic [15:0] sel, logic [1:0] cpl,
                                    logic [15:0] lim, logic [7:0] acc);
    expect_t e;
    bit stk = (tgt == 0);
    logic [1:0] rpl = sel[1:0];
    logic [1:0] dpl = acc[6:5];
    int selE = int'({sel[15:2], 2'b00});
    e.exc = 0; e.err = 0; e.accept = 0; e.hv = 0; e.fetch = 0; e.tag = "R10";
    if (sel[15:2] == 0) begin
      if (stk) begin e.exc = 1; e.tag = "R2"; end
      else begin e.accept = 1; e.tag = "R3"; end
      return e;
    end
    if ((sel | 16'h7) > lim) begin e.exc = 1; e.err = selE; e.tag = "R4"; return e; end
    if (stk && rpl != cpl) begin e.exc = 1; e.err = selE; e.tag = "R5"; return e; end
    e.fetch = 1;
    if (stk) begin
      if (!(acc[4] && !acc[3] && acc[1])) begin e.exc = 1; e.tag = "R6"; end
      else if (dpl != cpl)               begin e.exc = 1; e.tag = "R6"; end
      else if (!acc[7])                  begin e.exc = 2; e.tag = "R6"; end
    end else begin
      if (!(acc[4] && (!acc[3] || acc[1]))) begin e.exc = 1; e.tag = "R7"; end
      else if ((!acc[3] || !acc[2]) && (rpl > dpl || cpl > dpl)) begin e.exc = 1; e.tag = "R8"; end
      else if (!acc[7]) begin e.exc = 3; e.tag = "R9"; end
    end
    if (e.exc != 0) e.err = selE;
    else begin e.accept = 1; e.hv = 1; end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(int tgt, logic [15:0] sel, logic [1:0] cpl, logic [15:0] lim,
                       logic [7:0] acc, int dly, bit intrude);
    expect_t e;
    bit sawFetch = 0;
    bit gotDone = 0;
    int waitCnt = 0;
    e = model(tgt, sel, cpl, lim, acc);
    @(negedge clk);
    reqValid = 1'b1; reqTarget = TGT_W'(tgt); reqSel = sel; reqCpl = cpl; tableLimit = lim;
    @(negedge clk);
    if (intrude) begin
      // R11: a second request while busy must be ignored
      reqTarget = '0; reqSel = 16'h0001; reqCpl = ~cpl; tableLimit = '0;
    end else reqValid = 1'b0;
    for (int i = 0; i < 60; i++) begin
      fetchAck = 1'b0;
      if (doneStb) begin gotDone = 1; break; end
      if (fetchReq) begin
        sawFetch = 1;
        if (waitCnt >= dly) begin fetchAck = 1'b1; fetchAccess = acc; end
        else fetchAccess = ~acc;
        waitCnt++;
      end
      @(negedge clk);
      reqValid = 1'b0;
    end
    check(gotDone, e.tag, "done seen", int'(gotDone), 1);
    check(int'(excCode) == e.exc, e.tag, "excCode", int'(excCode), e.exc);
    check(int'(errCode) == e.err, e.tag, "errCode", int'(errCode), e.err);
    check(loadAccept == e.accept, e.tag, "loadAccept", int'(loadAccept), int'(e.accept));
    check(hiddenValid == e.hv, e.tag, "hiddenValid", int'(hiddenValid), int'(e.hv));
    check(sawFetch == e.fetch, e.tag, "fetch requested", int'(sawFetch), int'(e.fetch));
    @(negedge clk);
    // R10: strobes last one cycle
    check(!doneStb && !loadAccept, "R10", "strobe width", int'({doneStb, loadAccept}), 0);
  endtask

  initial begin
    #(900_000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !fetchReq && !doneStb && !loadAccept && !hiddenValid,
          "R1", "reset strobes", int'({busy, fetchReq, doneStb, loadAccept, hiddenValid}), 0);
    check(excCode == 2'd0 && errCode == 16'd0, "R1", "reset codes", int'(errCode), 0);

    // directed corner cases
    runOp(0, 16'h0003, 2'd3, 16'hFFFF, 8'hF2, 0, 0);   // R2 null stack
    runOp(2, 16'h0002, 2'd0, 16'hFFFF, 8'h00, 0, 0);   // R3 null data
    runOp(1, 16'h0010, 2'd0, 16'h0017, 8'h92, 0, 0);   // R10 exact limit edge
    runOp(1, 16'h0018, 2'd0, 16'h0017, 8'h92, 0, 0);   // R4 one past limit
    runOp(0, 16'h0019, 2'd0, 16'h0017, 8'h92, 0, 0);   // R4 before R5
    runOp(0, 16'h0011, 2'd0, 16'h00FF, 8'h92, 0, 0);   // R5
    runOp(0, 16'h0010, 2'd0, 16'h00FF, 8'h9A, 1, 0);   // R6 code not writable
    runOp(0, 16'h0012, 2'd2, 16'h00FF, 8'h92, 2, 0);   // R6 DPL mismatch
    runOp(0, 16'h0012, 2'd2, 16'h00FF, 8'h52, 0, 0);   // R6 stack fault
    runOp(0, 16'h0012, 2'd2, 16'h00FF, 8'hD2, 3, 1);   // R10 / R11 busy ignored
    runOp(3, 16'h0020, 2'd0, 16'h00FF, 8'h98, 0, 0);   // R7 execute-only code
    runOp(3, 16'h0020, 2'd0, 16'h00FF, 8'h82, 0, 0);   // R7 system descriptor
    runOp(4, 16'h0023, 2'd0, 16'h00FF, 8'hB2, 0, 0);   // R8 RPL above DPL
    runOp(4, 16'h0020, 2'd3, 16'h00FF, 8'hBA, 0, 0);   // R8 CPL above DPL, nonconforming
    runOp(4, 16'h0023, 2'd3, 16'h00FF, 8'h9E, 1, 0);   // R8 conforming readable skips
    runOp(1, 16'h0020, 2'd0, 16'h00FF, 8'h12, 0, 0);   // R9 not present
    runOp(7, 16'hFFF8, 2'd0, 16'hFFFF, 8'h92, 4, 0);   // R10 top index, target 7

    for (int n = 0; n < 600; n++) begin
      int tgt = $urandom_range(0, 7);
      logic [1:0] cpl = 2'($urandom_range(0, 3));
      logic [15:0] sel = 16'($urandom);
      logic [15:0] lim = 16'($urandom);
      logic [7:0] acc = 8'($urandom);
      if ($urandom_range(0, 7) == 0) sel = 16'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) sel[1:0] = cpl;
      if ($urandom_range(0, 1) == 1) lim = 16'hFFFF;
      if ($urandom_range(0, 1) == 1) begin acc[4] = 1'b1; acc[1] = 1'b1; end
      if ($urandom_range(0, 2) == 0) acc[6:5] = cpl;
      runOp(tgt, sel, cpl, lim, acc, $urandom_range(0, 3), bit'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule